// File: doc/BRIEF.md
# Three-Way Class Dispatch Router

This block sits between instruction decode and three per-class issue queues. Each cycle it can take a group of up to four decoded instructions into a twelve-entry in-order holding queue. From the oldest end of that queue it moves at most three instructions per cycle into one of three issue queues: floating-point, vector or general. The choice follows a two-bit class tag carried with each instruction. Each issue queue is a small FIFO with its own valid/ready output, so the three execution ports drain independently. As a result, instructions of different classes can leave out of program order.

Dispatch never reorders. It takes a prefix of the oldest waiting instructions and stops at the first one whose issue queue has no free slot, even if younger instructions target queues with room. Each dispatched instruction carries a sequence number that rises by one per instruction in program order, so a later completion stage can put results back in order. A fetch group is accepted whole or not at all. An instruction accepted at clock edge N can appear at an issue-queue output just after edge N+1.

Top module: `class_dispatch_router`

## Requirements
- R1: After reset all three issue-queue outputs are invalid and `fe_ready` is high for any group size from 0 to 4.
- R2: `fe_ready` is high exactly when the holding queue's free slots are at least `fe_count`; values above 4 count as 4. When `fe_valid` and `fe_ready` are both high at a clock edge, lanes 0 to `fe_count`-1 are taken as one group with lane 0 oldest. Lane i uses `fe_class[2i+1:2i]` and `fe_data[16i+15:16i]`. A refused group adds nothing.
- R3: The holding queue keeps up to twelve instructions. When it is full, any group of one or more is refused.
- R4: Class tag 2'b01 goes to the floating-point queue, 2'b10 goes to the vector queue, and 2'b00 and 2'b11 go to the general queue. Each queue delivers its instructions with their data unchanged, in program order.
- R5: At most three instructions leave the holding queue per cycle. A group of four of the same class is fully delivered.
- R6: Dispatch is in program order. An instruction whose issue queue is full blocks every younger instruction, even those bound for queues with room.
- R7: Each issue queue drains on its own ready. A younger instruction in one queue can be delivered while an older one waits in another queue.
- R8: Each issue queue holds four entries. While its valid is high and its ready is low, its data and sequence outputs stay unchanged. An entry is removed on a cycle with valid and ready both high.
- R9: Sequence numbers start at 0 after reset and rise by one for each instruction in program order, wrapping modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fe_valid | input | 1 | Fetch group offered |
| fe_count | input | 3 | Number of valid lanes in the group (0 to 4) |
| fe_class | input | 8 | Class tag per lane, 2 bits each |
| fe_data | input | 64 | Instruction payload per lane, 16 bits each |
| fe_ready | output | 1 | Room for the whole offered group |
| gen_valid | output | 1 | General queue has an entry |
| gen_ready | input | 1 | General execution port takes the entry |
| gen_data | output | 16 | General queue head payload |
| gen_seq | output | 8 | General queue head sequence number |
| fp_valid | output | 1 | Floating-point queue has an entry |
| fp_ready | input | 1 | Floating-point port takes the entry |
| fp_data | output | 16 | Floating-point queue head payload |
| fp_seq | output | 8 | Floating-point queue head sequence number |
| vec_valid | output | 1 | Vector queue has an entry |
| vec_ready | input | 1 | Vector port takes the entry |
| vec_data | output | 16 | Vector queue head payload |
| vec_seq | output | 8 | Vector queue head sequence number |

## Verification
Some properties are checked on every cycle:
- a refused fetch group never reduces the holding queue's free space;
- a full holding queue refuses any non-empty group;
- the sequence counter never advances by more than three in one cycle;
- each stalled issue-queue head holds its payload and sequence number steady.

Other behaviours can only be shown by the scenarios:
- the class steering;
- the blocking of younger instructions behind a full queue;
- one queue draining while another holds an older instruction;
- the exact moment a freed slot lets the holding queue accept a one-instruction group but not a two-instruction group.

// File: rtl/cdr_pkg.sv
`timescale 1ns/1ps
package cdr_pkg;
  parameter int DATA_W = 16;
  parameter int SEQ_W  = 8;
  parameter int CLS_W  = 2;

  localparam int NQ     = 3;
  localparam int QI_GEN = 0;
  localparam int QI_FP  = 1;
  localparam int QI_VEC = 2;

  localparam logic [CLS_W-1:0] CLS_FP  = 2'b01;
  localparam logic [CLS_W-1:0] CLS_VEC = 2'b10;

  typedef struct packed {
    logic [CLS_W-1:0]  cls;
    logic [DATA_W-1:0] data;
  } dq_item_t;

  typedef struct packed {
    logic [SEQ_W-1:0]  seq;
    logic [DATA_W-1:0] data;
  } iq_item_t;

  // class tag to issue-queue index; both remaining codes select the general queue
  function automatic logic [1:0] class_to_port(input logic [CLS_W-1:0] c);
    if (c == CLS_FP)  return 2'(QI_FP);
    if (c == CLS_VEC) return 2'(QI_VEC);
    return 2'(QI_GEN);
  endfunction
endpackage

// File: rtl/cdr_decode_q.sv
`timescale 1ns/1ps
// In-order holding queue: multi-entry push at the tail, multi-entry pop at the head.
module cdr_decode_q
  import cdr_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int IN_W  = 4,
  parameter int OUT_W = 3,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int NIW  = $clog2(IN_W + 1),
  localparam int NOW  = $clog2(OUT_W + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NIW-1:0]        push_n,
  input  dq_item_t [IN_W-1:0]   push_item,
  input  logic [NOW-1:0]        pop_n,
  output dq_item_t [OUT_W-1:0]  peek,
  output logic [OUT_W-1:0]      peek_vld,
  output logic [CW-1:0]         free_cnt
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SW = PW + 1;

  dq_item_t       mem_q [DEPTH];
  logic [PW-1:0]  head_q, head_d, tail;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           upd;

  function automatic logic [PW-1:0] ring(input logic [PW-1:0] base, input logic [SW-1:0] ofs);
    logic [SW:0] s;
    s = {2'b00, base} + {1'b0, ofs};
    if (s >= (SW+1)'(DEPTH)) s = s - (SW+1)'(DEPTH);
    return s[PW-1:0];
  endfunction

  assign tail     = ring(head_q, SW'(cnt_q));
  assign free_cnt = CW'(DEPTH) - cnt_q;

  always_comb begin
    for (int i = 0; i < OUT_W; i++) begin
      peek[i]     = mem_q[ring(head_q, SW'(i))];
      peek_vld[i] = (cnt_q > CW'(i));
    end
  end

  always_comb begin
    head_d = ring(head_q, SW'(pop_n));
    cnt_d  = cnt_q + CW'(push_n) - CW'(pop_n);
    upd    = (push_n != '0) || (pop_n != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      head_q <= head_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < IN_W; i++) begin
      if (NIW'(i) < push_n) mem_q[ring(tail, SW'(i))] <= push_item[i];
    end
  end
endmodule

// File: rtl/cdr_issue_q.sv
`timescale 1ns/1ps
// Per-class issue FIFO: several pushes per cycle, one pop through valid/ready.
module cdr_issue_q
  import cdr_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IN_W  = 3,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int NIW  = $clog2(IN_W + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NIW-1:0]       push_n,
  input  iq_item_t [IN_W-1:0]  push_item,
  output logic                 out_valid,
  input  logic                 out_ready,
  output iq_item_t             out_item,
  output logic [CW-1:0]        free_cnt
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SW = PW + 1;

  iq_item_t       mem_q [DEPTH];
  logic [PW-1:0]  head_q, head_d, tail;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           pop, upd;

  function automatic logic [PW-1:0] ring(input logic [PW-1:0] base, input logic [SW-1:0] ofs);
    logic [SW:0] s;
    s = {2'b00, base} + {1'b0, ofs};
    if (s >= (SW+1)'(DEPTH)) s = s - (SW+1)'(DEPTH);
    return s[PW-1:0];
  endfunction

  assign out_valid = (cnt_q != '0);
  assign out_item  = mem_q[head_q];
  assign free_cnt  = CW'(DEPTH) - cnt_q;
  assign tail      = ring(head_q, SW'(cnt_q));

  always_comb begin
    pop    = out_valid && out_ready;
    head_d = ring(head_q, SW'(pop));
    cnt_d  = cnt_q + CW'(push_n) - CW'(pop);
    upd    = pop || (push_n != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      head_q <= head_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < IN_W; i++) begin
      if (NIW'(i) < push_n) mem_q[ring(tail, SW'(i))] <= push_item[i];
    end
  end
endmodule

// File: rtl/cdr_steer.sv
`timescale 1ns/1ps
// Picks the in-order prefix of waiting instructions that fits and routes each by class.
module cdr_steer
  import cdr_pkg::*;
#(
  parameter int OUT_W = 3,
  parameter int IQ_CW = 3,
  localparam int NOW  = $clog2(OUT_W + 1)
) (
  input  dq_item_t [OUT_W-1:0]          peek,
  input  logic [OUT_W-1:0]              peek_vld,
  input  logic [NQ-1:0][IQ_CW-1:0]      iq_free,
  input  logic [SEQ_W-1:0]              seq_base,
  output logic [NOW-1:0]                pop_n,
  output logic [NQ-1:0][NOW-1:0]        push_n,
  output iq_item_t [NQ-1:0][OUT_W-1:0]  push_item
);
  logic       go;
  logic [1:0] port;

  always_comb begin
    go        = 1'b1;
    pop_n     = '0;
    push_n    = '0;
    push_item = '0;
    port      = '0;
    for (int i = 0; i < OUT_W; i++) begin
      port = class_to_port(peek[i].cls);
      if (go && peek_vld[i] && (IQ_CW'(push_n[port]) < iq_free[port])) begin
        push_item[port][push_n[port]] = '{seq: seq_base + SEQ_W'(i), data: peek[i].data};
        push_n[port] = push_n[port] + 1'b1;
        pop_n        = pop_n + 1'b1;
      end else begin
        go = 1'b0;
      end
    end
  end
endmodule

// File: rtl/class_dispatch_router.sv
`timescale 1ns/1ps
module class_dispatch_router
  import cdr_pkg::*;
#(
  parameter int FETCH_W  = 4,
  parameter int DQ_DEPTH = 12,
  parameter int DISP_W   = 3,
  parameter int IQ_DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fe_valid,
  input  logic [$clog2(FETCH_W+1)-1:0]  fe_count,
  input  logic [CLS_W*FETCH_W-1:0]      fe_class,
  input  logic [DATA_W*FETCH_W-1:0]     fe_data,
  output logic                          fe_ready,
  output logic                          gen_valid,
  input  logic                          gen_ready,
  output logic [DATA_W-1:0]             gen_data,
  output logic [SEQ_W-1:0]              gen_seq,
  output logic                          fp_valid,
  input  logic                          fp_ready,
  output logic [DATA_W-1:0]             fp_data,
  output logic [SEQ_W-1:0]              fp_seq,
  output logic                          vec_valid,
  input  logic                          vec_ready,
  output logic [DATA_W-1:0]             vec_data,
  output logic [SEQ_W-1:0]              vec_seq
);
  localparam int NFW   = $clog2(FETCH_W + 1);
  localparam int DQ_CW = $clog2(DQ_DEPTH + 1);
  localparam int IQ_CW = $clog2(IQ_DEPTH + 1);
  localparam int NDW   = $clog2(DISP_W + 1);

  logic [NFW-1:0]                  grp_n, dq_push_n;
  logic                            accept;
  dq_item_t [FETCH_W-1:0]          lane_items;
  dq_item_t [DISP_W-1:0]           peek;
  logic [DISP_W-1:0]               peek_vld;
  logic [DQ_CW-1:0]                dq_free;
  logic [NDW-1:0]                  pop_n;
  logic [NQ-1:0][IQ_CW-1:0]        iq_free;
  logic [NQ-1:0][NDW-1:0]          iq_push_n;
  iq_item_t [NQ-1:0][DISP_W-1:0]   iq_push_item;
  logic [NQ-1:0]                   iq_valid, iq_ready;
  iq_item_t [NQ-1:0]               iq_out;
  logic [SEQ_W-1:0]                seq_q, seq_d;

  // fetch side: whole-group acceptance
  always_comb begin
    grp_n     = (fe_count > NFW'(FETCH_W)) ? NFW'(FETCH_W) : fe_count;
    fe_ready  = (32'(dq_free) >= 32'(grp_n));
    accept    = fe_valid && fe_ready;
    dq_push_n = accept ? grp_n : '0;
  end

  for (genvar g = 0; g < FETCH_W; g++) begin : g_lane
    assign lane_items[g] = '{cls:  fe_class[g*CLS_W +: CLS_W],
                             data: fe_data[g*DATA_W +: DATA_W]};
  end

  cdr_decode_q #(.DEPTH(DQ_DEPTH), .IN_W(FETCH_W), .OUT_W(DISP_W)) u_dq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_n    (dq_push_n),
    .push_item (lane_items),
    .pop_n     (pop_n),
    .peek      (peek),
    .peek_vld  (peek_vld),
    .free_cnt  (dq_free)
  );

  cdr_steer #(.OUT_W(DISP_W), .IQ_CW(IQ_CW)) u_steer (
    .peek      (peek),
    .peek_vld  (peek_vld),
    .iq_free   (iq_free),
    .seq_base  (seq_q),
    .pop_n     (pop_n),
    .push_n    (iq_push_n),
    .push_item (iq_push_item)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_iq
    cdr_issue_q #(.DEPTH(IQ_DEPTH), .IN_W(DISP_W)) u_iq (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_n    (iq_push_n[q]),
      .push_item (iq_push_item[q]),
      .out_valid (iq_valid[q]),
      .out_ready (iq_ready[q]),
      .out_item  (iq_out[q]),
      .free_cnt  (iq_free[q])
    );
  end

  // program-order sequence counter, advanced by the dispatched count
  assign seq_d = seq_q + SEQ_W'(pop_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            seq_q <= '0;
    else if (pop_n != '0)  seq_q <= seq_d;
  end

  assign iq_ready  = {vec_ready, fp_ready, gen_ready};
  assign gen_valid = iq_valid[QI_GEN];
  assign gen_data  = iq_out[QI_GEN].data;
  assign gen_seq   = iq_out[QI_GEN].seq;
  assign fp_valid  = iq_valid[QI_FP];
  assign fp_data   = iq_out[QI_FP].data;
  assign fp_seq    = iq_out[QI_FP].seq;
  assign vec_valid = iq_valid[QI_VEC];
  assign vec_data  = iq_out[QI_VEC].data;
  assign vec_seq   = iq_out[QI_VEC].seq;
endmodule

// File: rtl/cdr_checker.sv
`timescale 1ns/1ps
module cdr_checker
  import cdr_pkg::*;
#(
  parameter int FETCH_W  = 4,
  parameter int DQ_DEPTH = 12,
  parameter int DISP_W   = 3,
  localparam int NFW     = $clog2(FETCH_W + 1),
  localparam int DQ_CW   = $clog2(DQ_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fe_valid,
  input logic [NFW-1:0]    fe_count,
  input logic              fe_ready,
  input logic [DQ_CW-1:0]  dq_free,
  input logic [SEQ_W-1:0]  seq_q,
  input logic              gen_valid,
  input logic              gen_ready,
  input logic [DATA_W-1:0] gen_data,
  input logic [SEQ_W-1:0]  gen_seq,
  input logic              fp_valid,
  input logic              fp_ready,
  input logic [DATA_W-1:0] fp_data,
  input logic [SEQ_W-1:0]  fp_seq,
  input logic              vec_valid,
  input logic              vec_ready,
  input logic [DATA_W-1:0] vec_data,
  input logic [SEQ_W-1:0]  vec_seq
);
  // R2
  refused_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_valid && !fe_ready) |=> (dq_free >= $past(dq_free)));

  // R3
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dq_free == '0) && (fe_count != '0)) |-> !fe_ready);

  // R5
  disp_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((seq_q - $past(seq_q)) <= SEQ_W'(DISP_W)));

  // R8
  gen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_valid && !gen_ready) |=> (gen_valid && $stable(gen_data) && $stable(gen_seq)));

  // R8
  fp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_valid && !fp_ready) |=> (fp_valid && $stable(fp_data) && $stable(fp_seq)));

  // R8
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_data) && $stable(vec_seq)));
endmodule

bind class_dispatch_router cdr_checker #(
  .FETCH_W(FETCH_W), .DQ_DEPTH(DQ_DEPTH), .DISP_W(DISP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fe_valid(fe_valid), .fe_count(fe_count),
  .fe_ready(fe_ready), .dq_free(dq_free), .seq_q(seq_q),
  .gen_valid(gen_valid), .gen_ready(gen_ready), .gen_data(gen_data), .gen_seq(gen_seq),
  .fp_valid(fp_valid), .fp_ready(fp_ready), .fp_data(fp_data), .fp_seq(fp_seq),
  .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_data(vec_data), .vec_seq(vec_seq)
);

// File: tb/class_dispatch_router_test.sv
`timescale 1ns/1ps
module class_dispatch_router_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fe_valid;
  logic [2:0]  fe_count;
  logic [7:0]  fe_class;
  logic [63:0] fe_data;
  logic        fe_ready;
  logic        gen_valid, gen_ready, fp_valid, fp_ready, vec_valid, vec_ready;
  logic [15:0] gen_data, fp_data, vec_data;
  logic [7:0]  gen_seq, fp_seq, vec_seq;

  int nchk = 0, nfail = 0;
  int wr[3], rd[3];
  int seq_ctr = 0, dcnt = 0;
  logic [15:0] exp_data [3][128];
  logic [7:0]  exp_seq  [3][128];

  always #4 clk = ~clk;

  class_dispatch_router uut (
    .clk(clk), .rst_n(rst_n), .fe_valid(fe_valid), .fe_count(fe_count),
    .fe_class(fe_class), .fe_data(fe_data), .fe_ready(fe_ready),
    .gen_valid(gen_valid), .gen_ready(gen_ready), .gen_data(gen_data), .gen_seq(gen_seq),
    .fp_valid(fp_valid), .fp_ready(fp_ready), .fp_data(fp_data), .fp_seq(fp_seq),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_data(vec_data), .vec_seq(vec_seq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // port index per R4: 0 general, 1 floating-point, 2 vector
  function automatic int port_of(input logic [1:0] c);
    if (c == 2'b01) return 1;
    if (c == 2'b10) return 2;
    return 0;
  endfunction

  // scoreboard: every handshake at an issue output is compared in order (R4, R9)
  always @(negedge clk) begin
    if (rst_n) begin
      for (int q = 0; q < 3; q++) begin
        logic v, r;
        logic [15:0] d;
        logic [7:0]  s;
        v = (q == 0) ? gen_valid : (q == 1) ? fp_valid : vec_valid;
        r = (q == 0) ? gen_ready : (q == 1) ? fp_ready : vec_ready;
        d = (q == 0) ? gen_data  : (q == 1) ? fp_data  : vec_data;
        s = (q == 0) ? gen_seq   : (q == 1) ? fp_seq   : vec_seq;
        if (v && r) begin
          if (rd[q] >= wr[q]) chk(1'b0, "R4", "unexpected delivery", q, -1);
          else begin
            chk(d == exp_data[q][rd[q]], "R4", "payload", d, exp_data[q][rd[q]]);
            chk(s == exp_seq[q][rd[q]],  "R9", "sequence", s, exp_seq[q][rd[q]]);
            rd[q]++;
          end
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #4;
  endtask

  task automatic set_ready(input logic g, input logic f, input logic v);
    @(posedge clk); #2;
    gen_ready = g; fp_ready = f; vec_ready = v;
  endtask

  task automatic send(input int n, input logic [7:0] cls);
    int waited = 0;
    @(posedge clk); #2;
    fe_valid = 1'b1; fe_count = 3'(n); fe_class = cls;
    for (int i = 0; i < 4; i++) fe_data[i*16 +: 16] = 16'(16'hC000 + dcnt + i);
    #2;
    while (!fe_ready && waited < 200) begin
      @(posedge clk); #4; waited++;
    end
    if (!fe_ready) chk(1'b0, "R2", "group never accepted", 0, 1);
    else begin
      for (int i = 0; i < n; i++) begin
        int q;
        q = port_of(cls[2*i +: 2]);
        exp_data[q][wr[q]] = 16'(16'hC000 + dcnt + i);
        exp_seq[q][wr[q]]  = 8'(seq_ctr);
        seq_ctr++; wr[q]++;
      end
      dcnt += n;
    end
    @(posedge clk); #2;
    fe_valid = 1'b0;
  endtask

  task automatic all_delivered(input string req);
    for (int q = 0; q < 3; q++) chk(rd[q] == wr[q], req, "delivered count", rd[q], wr[q]);
  endtask

  task automatic t_reset;
    #4;
    chk(!gen_valid && !fp_valid && !vec_valid, "R1", "valids after reset",
        {gen_valid, fp_valid, vec_valid}, 0);
    fe_count = 3'd4; #1;
    chk(fe_ready == 1'b1, "R1", "fe_ready after reset", fe_ready, 1);
    fe_count = 3'd0;
  endtask

  task automatic t_routing;
    send(4, {2'b11, 2'b10, 2'b01, 2'b00});
    cyc(8);
    all_delivered("R4");
  endtask

  task automatic t_four_same;
    send(4, {2'b00, 2'b11, 2'b00, 2'b11});
    cyc(10);
    chk(rd[0] == wr[0], "R5", "four general delivered", rd[0], wr[0]);
  endtask

  task automatic t_capacity;
    set_ready(1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) send(4, 8'h00);
    cyc(6);
    // general issue queue full (4), holding queue full (12)
    @(posedge clk); #2;
    fe_count = 3'd1; #2;
    chk(fe_ready == 1'b0, "R3", "full queue refuses one", fe_ready, 0);
    // release exactly one general entry
    @(posedge clk); #2; gen_ready = 1'b1;
    @(posedge clk); #2; gen_ready = 1'b0;
    @(posedge clk); #2;
    fe_count = 3'd1; #1;
    chk(fe_ready == 1'b1, "R2", "one free slot takes one", fe_ready, 1);
    fe_count = 3'd2; #1;
    chk(fe_ready == 1'b0, "R2", "one free slot refuses two", fe_ready, 0);
    fe_count = 3'd0;
    set_ready(1'b1, 1'b1, 1'b1);
    cyc(30);
    all_delivered("R3");
  endtask

  task automatic t_inorder_stall;
    set_ready(1'b1, 1'b0, 1'b1);
    send(4, 8'b01010101);
    cyc(4);
    send(2, {4'b0000, 2'b00, 2'b01});
    cyc(5);
    chk(rd[0] != wr[0], "R6", "younger general held back", rd[0], wr[0] - 1);
    chk(gen_valid == 1'b0, "R6", "general output idle while blocked", gen_valid, 0);
    set_ready(1'b1, 1'b1, 1'b1);
    cyc(12);
    all_delivered("R6");
  endtask

  task automatic t_independent;
    set_ready(1'b1, 1'b1, 1'b0);
    send(3, {2'b00, 2'b00, 2'b00, 2'b10});
    cyc(6);
    chk(rd[0] == wr[0], "R7", "younger general delivered", rd[0], wr[0]);
    chk(vec_valid == 1'b1, "R7", "older vector still waiting", vec_valid, 1);
    set_ready(1'b1, 1'b1, 1'b1);
    cyc(6);
    all_delivered("R7");
  endtask

  task automatic t_hold;
    logic [15:0] d0;
    logic [7:0]  s0;
    set_ready(1'b1, 1'b0, 1'b1);
    send(2, 8'b00000101);
    cyc(4);
    d0 = fp_data; s0 = fp_seq;
    chk(fp_valid == 1'b1, "R8", "fp valid while stalled", fp_valid, 1);
    chk(fp_data == exp_data[1][rd[1]], "R8", "fp head payload", fp_data, exp_data[1][rd[1]]);
    cyc(3);
    chk(fp_data == d0, "R8", "fp payload held", fp_data, d0);
    chk(fp_seq == s0, "R8", "fp sequence held", fp_seq, s0);
    set_ready(1'b1, 1'b1, 1'b1);
    cyc(6);
    all_delivered("R8");
  endtask

  initial begin
    #800000;
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int q = 0; q < 3; q++) begin wr[q] = 0; rd[q] = 0; end
    rst_n = 1'b0; fe_valid = 1'b0; fe_count = '0; fe_class = '0; fe_data = '0;
    gen_ready = 1'b1; fp_ready = 1'b1; vec_ready = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_routing();
    t_four_same();
    t_capacity();
    t_inorder_stall();
    t_independent();
    t_hold();
    chk(seq_ctr == rd[0] + rd[1] + rd[2], "R9", "sequence total", rd[0] + rd[1] + rd[2], seq_ctr);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule